// File: doc/BRIEF.md
# Delta-Modulation Sample Channel

This block plays 1-bit delta-modulated samples. Software programs a rate, a start code and a length code, then sets the channel's enable bit. The block then pulls sample bytes one at a time from memory through a DMA request port. It shifts each byte out least significant bit first, one bit per timer period. Each bit moves a 7-bit output level up or down by 2.

Each completed fetch holds the CPU for a fixed number of cycles. When a non-looping sample runs out, the block can raise an interrupt. That interrupt stays set until the next write to the channel-enable register. A direct-level write sets the output level at any time.

The DMA port is valid/ready. The block raises `dma_valid` with `dma_addr` when its one-byte buffer is empty and bytes remain. It holds both until `dma_ready` is seen. The byte on `dma_rdata` is taken in the same cycle that `dma_valid && dma_ready` is true. Memory applies back-pressure by holding `dma_ready` low; the block simply waits. The only case in which a request is withdrawn without a handshake is a write that clears the enable bit.

Top module: `dmc_sample_channel`

## Requirements
- R1: After reset the level is 0, and `active`, `irq`, `cpu_stall` and `dma_valid` are all 0.
- R2: `reg_wr_sel` selects the written register: 0 = control (bit 7 interrupt enable, bit 6 loop, bits 3:0 rate), 1 = level, 2 = start code, 3 = length code. A write to the enable register with `en_bit`=1 while no bytes remain has two effects. It sets the address to 0xC000 + start×64 and the byte count to length×16 + 1. Because the buffer is empty, `dma_valid` is then raised in the next cycle.
- R3: Each handshake advances the address by one, wrapping from 0xFFFF to 0x8000, and lowers the byte count by one. While `dma_ready` is low, `dma_valid` and `dma_addr` hold steady.
- R4: `cpu_stall` is high for exactly the 4 cycles that follow each handshake.
- R5: A handshake of the last byte with loop off sets `irq` in the next cycle if control bit 7 is 1. If bit 7 is 0, `irq` stays 0.
- R6: With loop on, the last byte's handshake reloads the start address and length. `active` stays 1 and no interrupt is raised.
- R7: Any write to the enable register clears `irq` in the next cycle. With `en_bit`=0 it also zeroes the byte count, so `active` reads 0 in the next cycle.
- R8: A level write loads bits 6:0 of `reg_wr_data` into `level` in the next cycle; bit 7 is ignored.
- R9: Bits of a fetched byte are played LSB first. A 1 raises the level by 2 and a 0 lowers it by 2.
- R10: The level saturates. A step that would go below 0 or above 127 is skipped, and the level is left unchanged.
- R11: Played bits are spaced by the rate period in cycles. Rate 15 gives 54 cycles and rate 0 gives 428 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (one CPU cycle) |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select (see R2) |
| reg_wr_data | input | 8 | Register write data |
| en_wr | input | 1 | Write strobe of the channel-enable register |
| en_bit | input | 1 | This channel's enable bit in that write |
| dma_valid | output | 1 | Fetch request valid |
| dma_ready | input | 1 | Memory accepts the request; data valid |
| dma_addr | output | 16 | Fetch address |
| dma_rdata | input | 8 | Fetched sample byte |
| level | output | 7 | Output level |
| active | output | 1 | Bytes remaining is nonzero |
| irq | output | 1 | Sample-end interrupt flag |
| cpu_stall | output | 1 | CPU hold request after a fetch |

## Verification
Register and enable writes take effect at the next clock edge. So `level` (R8), `active`, `irq` (R7) and the first `dma_valid` (R2) are sampled at the first falling edge after the write's edge. The interrupt is due one cycle after the last handshake, and `cpu_stall` covers the four cycles after each handshake. A bench model is stepped on every falling edge from the inputs visible there, and it predicts `active`, `irq` and `cpu_stall` for the next falling edge. Level steps lag the internal bit tick by one register. The bench therefore does not fix their absolute phase: it checks the direction of each step and that successive steps are exactly one rate period apart.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_LEVEL = 2'd1,
    REG_START = 2'd2,
    REG_LEN   = 2'd3
  } dmc_reg_e;

  localparam logic [15:0] SAMPLE_BASE = 16'hC000;
  localparam logic [15:0] WRAP_TO     = 16'h8000;
  localparam int          PERIOD_W    = 9;

  // Bit period in cycles for each rate index.
  function automatic logic [PERIOD_W-1:0] rate_period(input logic [3:0] idx);
    case (idx)
      4'd0:  return 9'd428;
      4'd1:  return 9'd380;
      4'd2:  return 9'd340;
      4'd3:  return 9'd320;
      4'd4:  return 9'd286;
      4'd5:  return 9'd254;
      4'd6:  return 9'd226;
      4'd7:  return 9'd214;
      4'd8:  return 9'd190;
      4'd9:  return 9'd160;
      4'd10: return 9'd142;
      4'd11: return 9'd128;
      4'd12: return 9'd106;
      4'd13: return 9'd84;
      4'd14: return 9'd72;
      default: return 9'd54;
    endcase
  endfunction
endpackage

// File: rtl/dmc_rate_timer.sv
module dmc_rate_timer
  import dmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] rate,
  output logic       tick
);
  logic [PERIOD_W-1:0] cnt_q;

  assign tick = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (tick)    cnt_q <= rate_period(rate) - 1'b1;
    else              cnt_q <= cnt_q - 1'b1;
  end

  // Shortest period is far above one cycle: ticks never come back to back.
  assert_tick_spacing_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/dmc_fetch.sv
module dmc_fetch
  import dmc_pkg::*;
#(
  parameter int STALL_CYCLES = 4,
  parameter int CODE_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_wr,
  input  logic              en_bit,
  input  logic              irq_en,
  input  logic              loop_en,
  input  logic [CODE_W-1:0] start_code,
  input  logic [CODE_W-1:0] len_code,
  input  logic              buf_take,
  output logic              buf_valid,
  output logic [7:0]        buf_data,
  output logic              dma_valid,
  input  logic              dma_ready,
  output logic [15:0]       dma_addr,
  input  logic [7:0]        dma_rdata,
  output logic              active,
  output logic              irq,
  output logic              cpu_stall
);
  localparam int REM_W   = CODE_W + 5;
  localparam int STALL_W = $clog2(STALL_CYCLES + 1);

  logic [15:0]        addr_q;
  logic [REM_W-1:0]   rem_q;
  logic [STALL_W-1:0] stall_q;
  logic               hs;
  logic [15:0]        addr_next, start_addr;
  logic [REM_W-1:0]   start_len;

  assign start_addr = SAMPLE_BASE + {2'b00, start_code, 6'b0};
  assign start_len  = {1'b0, len_code, 4'b0} + 1'b1;
  assign addr_next  = (addr_q == 16'hFFFF) ? WRAP_TO : addr_q + 1'b1;
  assign dma_valid  = !buf_valid && (rem_q != '0);
  assign dma_addr   = addr_q;
  assign hs         = dma_valid && dma_ready;
  assign active     = (rem_q != '0);
  assign cpu_stall  = (stall_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_valid <= 1'b0;
      buf_data  <= '0;
      stall_q   <= '0;
    end else begin
      if (hs) begin
        buf_valid <= 1'b1;
        buf_data  <= dma_rdata;
      end else if (buf_take) begin
        buf_valid <= 1'b0;
      end
      if (hs)                stall_q <= STALL_W'(STALL_CYCLES);
      else if (stall_q != 0) stall_q <= stall_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= SAMPLE_BASE;
      rem_q  <= '0;
      irq    <= 1'b0;
    end else if (en_wr) begin
      irq <= 1'b0;
      if (!en_bit) begin
        rem_q <= '0;
      end else if (rem_q == '0) begin
        addr_q <= start_addr;
        rem_q  <= start_len;
      end
    end else if (hs) begin
      if (rem_q == REM_W'(1)) begin
        if (loop_en) begin
          addr_q <= start_addr;
          rem_q  <= start_len;
        end else begin
          addr_q <= addr_next;
          rem_q  <= '0;
          if (irq_en) irq <= 1'b1;
        end
      end else begin
        addr_q <= addr_next;
        rem_q  <= rem_q - 1'b1;
      end
    end
  end

  assert_stall_follows_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> cpu_stall);
  assert_request_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_valid && !dma_ready && !en_wr) |=> (dma_valid && $stable(dma_addr)));
  assert_irq_needs_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !hs) |=> !irq);
  assert_irq_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> !irq);
endmodule

// File: rtl/dmc_output.sv
module dmc_output #(
  parameter int LEVEL_W = 7,
  parameter int STEP    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               lvl_wr,
  input  logic [LEVEL_W-1:0] lvl_data,
  input  logic               buf_valid,
  input  logic [7:0]         buf_data,
  output logic               buf_take,
  output logic [LEVEL_W-1:0] level
);
  localparam int LVL_MAX = (1 << LEVEL_W) - 1;

  logic [7:0] shift_q;
  logic [3:0] bits_q;
  logic       silent_q;
  logic       last_bit;

  assign last_bit = (bits_q == 4'd1);
  assign buf_take = tick && last_bit && buf_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q  <= '0;
      bits_q   <= 4'd8;
      silent_q <= 1'b1;
      level    <= '0;
    end else begin
      if (tick) begin
        shift_q <= shift_q >> 1;
        if (last_bit) begin
          bits_q <= 4'd8;
          if (buf_valid) begin
            shift_q  <= buf_data;
            silent_q <= 1'b0;
          end else begin
            silent_q <= 1'b1;
          end
        end else begin
          bits_q <= bits_q - 1'b1;
        end
      end
      if (lvl_wr) begin
        level <= lvl_data;
      end else if (tick && !silent_q) begin
        if (shift_q[0]) begin
          if (int'(level) <= LVL_MAX - STEP) level <= level + LEVEL_W'(STEP);
        end else begin
          if (int'(level) >= STEP) level <= level - LEVEL_W'(STEP);
        end
      end
    end
  end

  assert_level_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_wr |=> (level == $past(level) || level == $past(level) + LEVEL_W'(STEP)
                 || level + LEVEL_W'(STEP) == $past(level)));
endmodule

// File: rtl/dmc_sample_channel.sv
module dmc_sample_channel
  import dmc_pkg::*;
#(
  parameter int LEVEL_W      = 7,
  parameter int STALL_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic [1:0]         reg_wr_sel,
  input  logic [7:0]         reg_wr_data,
  input  logic               en_wr,
  input  logic               en_bit,
  output logic               dma_valid,
  input  logic               dma_ready,
  output logic [15:0]        dma_addr,
  input  logic [7:0]         dma_rdata,
  output logic [LEVEL_W-1:0] level,
  output logic               active,
  output logic               irq,
  output logic               cpu_stall
);
  logic       irq_en_q, loop_q;
  logic [3:0] rate_q;
  logic [7:0] start_q, len_q;
  logic       tick, buf_take, buf_valid, lvl_wr;
  logic [7:0] buf_data;
  dmc_reg_e   sel;

  assign sel    = dmc_reg_e'(reg_wr_sel);
  assign lvl_wr = reg_wr_en && (sel == REG_LEVEL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en_q <= 1'b0;
      loop_q   <= 1'b0;
      rate_q   <= '0;
      start_q  <= '0;
      len_q    <= '0;
    end else if (reg_wr_en) begin
      case (sel)
        REG_CTRL: begin
          irq_en_q <= reg_wr_data[7];
          loop_q   <= reg_wr_data[6];
          rate_q   <= reg_wr_data[3:0];
        end
        REG_START: start_q <= reg_wr_data;
        REG_LEN:   len_q   <= reg_wr_data;
        default: ;
      endcase
    end
  end

  dmc_rate_timer u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .rate (rate_q),
    .tick (tick)
  );

  dmc_fetch #(.STALL_CYCLES(STALL_CYCLES), .CODE_W(8)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_wr     (en_wr),
    .en_bit    (en_bit),
    .irq_en    (irq_en_q),
    .loop_en   (loop_q),
    .start_code(start_q),
    .len_code  (len_q),
    .buf_take  (buf_take),
    .buf_valid (buf_valid),
    .buf_data  (buf_data),
    .dma_valid (dma_valid),
    .dma_ready (dma_ready),
    .dma_addr  (dma_addr),
    .dma_rdata (dma_rdata),
    .active    (active),
    .irq       (irq),
    .cpu_stall (cpu_stall)
  );

  dmc_output #(.LEVEL_W(LEVEL_W), .STEP(2)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .lvl_wr   (lvl_wr),
    .lvl_data (reg_wr_data[LEVEL_W-1:0]),
    .buf_valid(buf_valid),
    .buf_data (buf_data),
    .buf_take (buf_take),
    .level    (level)
  );
endmodule

// File: tb/sim_dmc_sample_channel.sv
module sim_dmc_sample_channel;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr_en = 1'b0, en_wr = 1'b0, en_bit = 1'b0, dma_ready = 1'b0;
  logic [1:0]  reg_wr_sel = '0;
  logic [7:0]  reg_wr_data = '0, dma_rdata = '0;
  logic        dma_valid, active, irq, cpu_stall;
  logic [15:0] dma_addr;
  logic [6:0]  level;

  int checks = 0, failures = 0, cyc = 0, rdy_mode = 0, fetches = 0;
  logic mon_on = 1'b0, saw_wrap = 1'b0;
  // reference model state
  logic        m_ie = 0, m_loop = 0, m_irq = 0;
  logic [7:0]  m_start = 0, m_len = 0;
  logic [15:0] m_addr = 16'hC000, last_fetch = 0;
  int          m_rem = 0, m_stall = 0;

  dmc_sample_channel u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] f_start(input logic [7:0] c);
    return 16'hC000 + {2'b00, c, 6'b0};
  endfunction
  function automatic int f_len(input logic [7:0] c);
    return int'(c) * 16 + 1;
  endfunction
  function automatic logic [15:0] f_next(input logic [15:0] a);
    return (a == 16'hFFFF) ? 16'h8000 : a + 16'd1;
  endfunction

  always @(posedge clk) begin
    cyc++;
    #1;
    dma_ready = (rdy_mode == 2) ? 1'($urandom % 2) : 1'(rdy_mode);
    if (cyc > 190000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Cycle model: compare, then step from the inputs seen now.
  always @(negedge clk) if (mon_on) begin
    bit hs;
    chk(active == (m_rem != 0), "R3 active", active, m_rem != 0);
    chk(irq == m_irq, "R5/R7 irq", irq, m_irq);
    chk(cpu_stall == (m_stall != 0), "R4 stall", cpu_stall, m_stall != 0);
    hs = dma_valid && dma_ready;
    if (hs) begin
      chk(dma_addr == m_addr, "R3 addr", dma_addr, m_addr);
      if (last_fetch == 16'hFFFF && dma_addr == 16'h8000) saw_wrap = 1'b1;
      last_fetch = dma_addr;
      fetches++;
    end
    m_stall = hs ? 4 : (m_stall > 0 ? m_stall - 1 : 0);
    if (en_wr) begin
      m_irq = 0;
      if (!en_bit) m_rem = 0;
      else if (m_rem == 0) begin m_addr = f_start(m_start); m_rem = f_len(m_len); end
    end else if (hs) begin
      if (m_rem == 1) begin
        if (m_loop) begin m_addr = f_start(m_start); m_rem = f_len(m_len); end
        else begin m_addr = f_next(m_addr); m_rem = 0; if (m_ie) m_irq = 1; end
      end else begin m_addr = f_next(m_addr); m_rem = m_rem - 1; end
    end
    if (reg_wr_en) begin
      if (reg_wr_sel == 2'd0) begin m_ie = reg_wr_data[7]; m_loop = reg_wr_data[6]; end
      if (reg_wr_sel == 2'd2) m_start = reg_wr_data;
      if (reg_wr_sel == 2'd3) m_len = reg_wr_data;
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(posedge clk); #1;
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
    @(posedge clk); #1;
    reg_wr_en = 1'b0;
  endtask

  task automatic enw(input logic b);
    @(posedge clk); #1;
    en_wr = 1'b1; en_bit = b;
    @(posedge clk); #1;
    en_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  // Follow level steps: direction from pattern bits (LSB first), spacing = period.
  task automatic track(input int nchg, input int period, input logic [7:0] pat, input int maxw);
    int k = 0, last = -1, t = 0;
    int prev;
    @(negedge clk);
    prev = level;
    while (k < nchg && t < maxw) begin
      @(negedge clk); t++;
      if (int'(level) != prev) begin
        chk(int'(level) == (pat[k] ? prev + 2 : prev - 2), "R9 step", level, pat[k] ? prev + 2 : prev - 2);
        if (last >= 0) chk(t - last == period, "R11 spacing", t - last, period);
        last = t; prev = level; k++;
      end
    end
    chk(k == nchg, "R9 step count", k, nchg);
  endtask

  initial begin
    void'($urandom(32'd2024));
    idle(3);
    @(negedge clk);
    // R1 reset state
    chk(level == 0, "R1 level", level, 0);
    chk(!active && !irq && !cpu_stall && !dma_valid, "R1 flags",
        {active, irq, cpu_stall, dma_valid}, 0);
    @(posedge clk); #1 rst_n = 1'b1; mon_on = 1'b1;

    // R8 direct level, bit 7 ignored
    wr(2'd1, 8'h85);
    @(negedge clk); chk(level == 7'd5, "R8 level load", level, 5);

    // R2 start request, memory holding off
    rdy_mode = 0;
    wr(2'd0, 8'h0F); wr(2'd2, 8'd2); wr(2'd3, 8'd0);
    enw(1'b1);
    @(negedge clk);
    chk(dma_valid, "R2 request", dma_valid, 1);
    chk(dma_addr == 16'hC080, "R2 start addr", dma_addr, 16'hC080);
    idle(5);
    @(negedge clk);
    chk(dma_valid && dma_addr == 16'hC080, "R3 hold", dma_addr, 16'hC080);
    rdy_mode = 1;
    idle(2000);

    // R9/R11 falling steps at rate 15
    dma_rdata = 8'h00;
    wr(2'd1, 8'd100); wr(2'd2, 8'd0);
    enw(1'b1);
    track(8, 54, 8'h00, 2000);
    @(negedge clk); chk(level == 7'd84, "R9 final down", level, 84);
    idle(1000);

    // R9/R11 alternating pattern at rate 0, LSB first
    wr(2'd0, 8'h00); dma_rdata = 8'h55; wr(2'd1, 8'd64);
    enw(1'b1);
    track(8, 428, 8'h55, 8000);
    @(negedge clk); chk(level == 7'd64, "R9 final alt", level, 64);
    idle(4000);

    // R10 saturation high and low
    wr(2'd0, 8'h0F); dma_rdata = 8'hFF; wr(2'd1, 8'd120);
    enw(1'b1); idle(2000);
    @(negedge clk); chk(level == 7'd126, "R10 top", level, 126);
    dma_rdata = 8'h00; wr(2'd1, 8'd3);
    enw(1'b1); idle(2000);
    @(negedge clk); chk(level == 7'd1, "R10 bottom", level, 1);

    // R3 wrap, no irq with bit 7 clear (R5)
    wr(2'd2, 8'hFF); wr(2'd3, 8'd4);
    enw(1'b1);
    for (int i = 0; i < 40000 && active; i++) @(posedge clk);
    idle(1000);
    @(negedge clk);
    chk(saw_wrap, "R3 wrap", saw_wrap, 1);
    chk(!irq, "R5 irq disabled", irq, 0);

    // R6 looping sample
    wr(2'd0, 8'h4F); wr(2'd2, 8'd3); wr(2'd3, 8'd0);
    fetches = 0;
    enw(1'b1); idle(3000);
    @(negedge clk);
    chk(active && !irq, "R6 loop active", {active, irq}, 2);
    chk(fetches >= 3, "R6 refetch", fetches, 3);
    enw(1'b0);
    @(negedge clk); chk(!active, "R7 disable", active, 0);
    idle(1000);

    // Random rounds: R2 R3 R4 R5 R7
    rdy_mode = 2;
    for (int r = 0; r < 6; r++) begin
      logic ie;
      ie = 1'($urandom % 2);
      dma_rdata = 8'($urandom);
      wr(2'd0, {ie, 3'b000, 4'hF});
      wr(2'd2, 8'($urandom));
      wr(2'd3, 8'($urandom % 2));
      enw(1'b1);
      for (int i = 0; i < 20000 && active; i++) @(posedge clk);
      idle(1200);
      @(negedge clk);
      chk(irq == ie, "R5 irq end", irq, ie);
      enw(1'b1);
      @(negedge clk);
      chk(!irq, "R7 clear", irq, 0);
      enw(1'b0);
      idle(1200);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule